// File: doc/BRIEF.md
# Asynchronous Strobe Bus Slave Port

This block connects an asynchronous microprocessor bus to a clocked register and memory space. The host selects the device with an active-low chip select and marks the access with an active-low data strobe. A direction line picks read or write. The address is 15 bits wide and the data is 16 bits wide. The port brings both strobes into the core clock domain. It then issues exactly one request on a simple internal request/acknowledge interface. For a read it puts the returned word on the bus, and only after that does it pull the active-low transfer acknowledge low.

The acknowledge stays low until the host removes either strobe. It is then driven high for one clock and finally released to high impedance, where an external pull-up holds it. The block provides only the value and enable of each three-state signal; the pad drivers are outside it. The host must leave a minimum gap between the acknowledge going high and the start of its next access.

Top module: `mp_port`

## Requirements
- R1: A request starts only after chip select and data strobe are both low. The start comes through a two-flop synchronizer, so `req_o` rises on the third rising clock edge after both strobes go low. Either strobe alone never produces a request or an acknowledge.
- R2: `rw_i`=1 selects a read and `rw_i`=0 a write. `req_we_o` is the inverse of `rw_i`. During a read, `data_oe_o` is high and `rdata_o` carries the word returned on `req_rdata_i`. During a write, `data_oe_o` stays low.
- R3: The 15-bit address (bit 0 least significant) reaches `req_addr_o` unchanged. For a write, the 16-bit data word (bit 0 least significant) reaches `req_wdata_o` unchanged.
- R4: `req_o` stays high until `req_ack_i` is sampled high and falls on the next edge. Each host access produces exactly one internal request.
- R5: For a read, `data_oe_o` is high at least one cycle before the acknowledge goes low. `rdata_o` then holds its value until the strobe removal has been synchronized.
- R6: While a strobe is asserted, the acknowledge is driven low (`ack_oe_o`=1, `ack_n_o`=0). Once either strobe rises, it stays low for the two synchronizer cycles. It is then driven high for exactly one cycle, after which `ack_oe_o` falls.
- R7: An active-low `rst_ni` asynchronously forces `req_o`, `data_oe_o` and `ack_oe_o` low and returns the port to idle. Reset is released on a clock edge.
- R8: The host starts no new access sooner than 30 ns (6 cycles at 200 MHz) after the acknowledge is driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| ds_ni | input | 1 | Data strobe, active low, asynchronous |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 15 | Bus address, bit 0 LSB |
| wdata_i | input | 16 | Data driven by the host, bit 0 LSB |
| rdata_o | output | 16 | Data driven toward the host |
| data_oe_o | output | 1 | Enable for the data bus driver |
| ack_n_o | output | 1 | Acknowledge value, active low |
| ack_oe_o | output | 1 | Enable for the acknowledge driver |
| req_o | output | 1 | Internal access request |
| req_we_o | output | 1 | Internal request is a write |
| req_addr_o | output | 15 | Internal request address |
| req_wdata_o | output | 16 | Internal write data |
| req_ack_i | input | 1 | Internal completion pulse |
| req_rdata_i | input | 16 | Internal read data, valid with `req_ack_i` |

## Verification
The assertions check the following on every cycle:
- the request is held and dropped around the internal acknowledge;
- a request never starts without both synchronized strobes;
- read data is enabled before the acknowledge falls and stays stable while enabled;
- the acknowledge is driven high before it is released.

Only the bench scenarios can show the following:
- the exact synchronizer latency on release;
- the addresses and data carried end to end, including read-after-write over all 15 address bits;
- the count of exactly one request per access;
- that a single strobe is ignored;
- the asynchronous reset in the middle of an access;
- the host-side gap rule.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int unsigned MP_AW = 15;
  localparam int unsigned MP_DW = 16;
  localparam int unsigned MP_SYNC = 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_DRV  = 3'd2,
    ST_ACK  = 3'd3,
    ST_REL  = 3'd4
  } mp_state_e;
endpackage

// File: rtl/mp_sync.sv
module mp_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= {WIDTH{RST_V}};
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mp_ctrl.sv
module mp_ctrl
  import mp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic we_i,
  input  logic req_ack_i,
  output logic req_o,
  output logic cap_cmd_o,
  output logic cap_rd_o,
  output logic data_oe_o,
  output logic ack_n_o,
  output logic ack_oe_o
);
  mp_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  // IDLE is entered only after the strobes were seen released, so a level here is a new access
  always_comb begin
    state_d   = state_q;
    cap_cmd_o = 1'b0;
    cap_rd_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (active_i) begin
        state_d   = ST_REQ;
        cap_cmd_o = 1'b1;
      end
      ST_REQ: if (req_ack_i) begin
        state_d  = ST_DRV;
        cap_rd_o = 1'b1;
      end
      ST_DRV:  state_d = ST_ACK;
      ST_ACK:  if (!active_i) state_d = ST_REL;
      ST_REL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign req_o     = (state_q == ST_REQ);
  assign data_oe_o = !we_i && ((state_q == ST_DRV) || (state_q == ST_ACK));
  assign ack_oe_o  = (state_q == ST_ACK) || (state_q == ST_REL);
  assign ack_n_o   = (state_q != ST_ACK);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !req_ack_i) |=> req_o); // R4
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && req_ack_i) |=> !req_o); // R4
  AST_REQ_NEEDS_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(active_i)); // R1
  AST_ACK_HIGH_BEFORE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_oe_o) |-> $past(ack_n_o)); // R6
endmodule

// File: rtl/mp_dpath.sv
module mp_dpath #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_cmd_i,
  input  logic          cap_rd_i,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rdata_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (cap_cmd_i) begin
      // bus lines have been stable for the whole strobe synchronizer delay
      we_o    <= !rw_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (cap_rd_i && !we_o) rdata_o <= rdata_i;
  end
endmodule

// File: rtl/mp_port.sv
module mp_port
  import mp_pkg::*;
#(
  parameter int unsigned AW     = MP_AW,
  parameter int unsigned DW     = MP_DW,
  parameter int unsigned STAGES = MP_SYNC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          ds_ni,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          data_oe_o,
  output logic          ack_n_o,
  output logic          ack_oe_o,
  output logic          req_o,
  output logic          req_we_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          req_ack_i,
  input  logic [DW-1:0] req_rdata_i
);
  logic [1:0] strb_s;
  logic       active;
  logic       cap_cmd, cap_rd;

  mp_sync #(.WIDTH(2), .STAGES(STAGES), .RST_V(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, ds_ni}),
    .q_o   (strb_s)
  );

  assign active = (strb_s == 2'b00);

  mp_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .we_i     (req_we_o),
    .req_ack_i(req_ack_i),
    .req_o    (req_o),
    .cap_cmd_o(cap_cmd),
    .cap_rd_o (cap_rd),
    .data_oe_o(data_oe_o),
    .ack_n_o  (ack_n_o),
    .ack_oe_o (ack_oe_o)
  );

  mp_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_cmd_i(cap_cmd),
    .cap_rd_i (cap_rd),
    .rw_i     (rw_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_i  (req_rdata_i),
    .we_o     (req_we_o),
    .addr_o   (req_addr_o),
    .wdata_o  (req_wdata_o),
    .rdata_o  (rdata_o)
  );

  AST_DATA_BEFORE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_oe_o && !ack_n_o && !$past(ack_oe_o && !ack_n_o) && !req_we_o) |-> $past(data_oe_o)); // R5
  AST_RDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o)) |-> $stable(rdata_o)); // R5
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_we_o |-> !data_oe_o); // R2
endmodule

// File: tb/mp_port_bench.sv
`timescale 1ns/1ps
module mp_port_bench;
  localparam int AW = 15;
  localparam int DW = 16;
  localparam time GAP = 30ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata_o, req_wdata_o, req_rdata_i;
  logic [AW-1:0] req_addr_o;
  logic data_oe_o, ack_n_o, ack_oe_o, req_o, req_we_o;
  logic req_ack_i;

  int total = 0, bad = 0;
  time t_rel = 0;

  always #2.5 clk = ~clk;

  mp_port u_mp_port (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ds_ni(ds_n), .rw_i(rw),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .data_oe_o(data_oe_o),
    .ack_n_o(ack_n_o), .ack_oe_o(ack_oe_o), .req_o(req_o), .req_we_o(req_we_o),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
    .req_ack_i(req_ack_i), .req_rdata_i(req_rdata_i)
  );

  function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
    return {1'b0, a} ^ 16'h5A3C;
  endfunction

  // internal slave model
  logic [DW-1:0] smem [logic [AW-1:0]];
  logic [DW-1:0] model [logic [AW-1:0]];
  int slave_ops = 0;
  int unsigned wait_cnt = 0;
  logic [AW-1:0] last_addr = '0;
  logic last_we = 1'b0;
  logic [DW-1:0] last_wdata = '0;

  always @(posedge clk) begin
    req_ack_i <= 1'b0;
    if (req_o && !req_ack_i) begin
      if (wait_cnt == 0) begin
        req_ack_i  <= 1'b1;
        slave_ops  <= slave_ops + 1;
        last_addr  <= req_addr_o;
        last_we    <= req_we_o;
        last_wdata <= req_wdata_o;
        if (req_we_o) smem[req_addr_o] = req_wdata_o;
        req_rdata_i <= smem.exists(req_addr_o) ? smem[req_addr_o] : dflt(req_addr_o);
        wait_cnt   <= $urandom % 4;
      end else wait_cnt <= wait_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    return model.exists(a) ? model[a] : dflt(a);
  endfunction

  task automatic do_access(input logic r, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    int ops0, to;
    logic prev_oe;
    logic [DW-1:0] expd, held;
    bit rel_ds, ok_hold;
    while (($time - t_rel) < GAP) @(negedge clk);
    chk(($time - t_rel) >= GAP, "R8 gap", 32'($time - t_rel), 32'(GAP));
    ops0 = slave_ops;
    expd = exp_rd(a);
    rw = r; addr = a; wdata = wd; cs_n = 1'b0; ds_n = 1'b0;
    to = 0; prev_oe = 1'b0;
    while (!(ack_oe_o && !ack_n_o) && to < 64) begin
      prev_oe = data_oe_o;
      @(negedge clk);
      to++;
    end
    chk(to < 64, "R6 ack asserted", 32'(to), 32'd64);
    if (r) begin
      chk(prev_oe, "R5 data before ack", 32'(prev_oe), 32'd1);
      chk(data_oe_o && rdata_o == expd, "R2 read data", 32'(rdata_o), 32'(expd));
    end else begin
      chk(!data_oe_o, "R2 no drive on write", 32'(data_oe_o), 32'd0);
      model[a] = wd;
      chk(last_wdata == wd, "R3 write data", 32'(last_wdata), 32'(wd));
    end
    chk(slave_ops == ops0 + 1, "R4 one request", 32'(slave_ops - ops0), 32'd1);
    chk(last_addr == a, "R3 address", 32'(last_addr), 32'(a));
    chk(last_we == !r, "R2 direction", 32'(last_we), 32'(!r));
    held = rdata_o;
    ok_hold = 1'b1;
    repeat (1 + $urandom % 3) begin
      @(negedge clk);
      if (!(ack_oe_o && !ack_n_o)) ok_hold = 1'b0;
      if (r && (!data_oe_o || rdata_o != held)) ok_hold = 1'b0;
    end
    rel_ds = ($urandom % 2) == 1;
    if (rel_ds) ds_n = 1'b1; else cs_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      if (!(ack_oe_o && !ack_n_o)) ok_hold = 1'b0;
      if (r && (!data_oe_o || rdata_o != held)) ok_hold = 1'b0;
    end
    chk(ok_hold, "R6 ack held low until strobe synced", 32'(ok_hold), 32'd1);
    @(negedge clk);
    chk(ack_oe_o && ack_n_o, "R6 ack driven high", {30'd0, ack_oe_o, ack_n_o}, 32'd3);
    t_rel = $time;
    @(negedge clk);
    chk(!ack_oe_o, "R6 ack released", 32'(ack_oe_o), 32'd0);
    cs_n = 1'b1; ds_n = 1'b1;
  endtask

  task automatic single_strobe(input bit use_cs);
    bit seen = 1'b0;
    cs_n = use_cs ? 1'b0 : 1'b1;
    ds_n = use_cs ? 1'b1 : 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (req_o || ack_oe_o) seen = 1'b1;
    end
    chk(!seen, use_cs ? "R1 cs alone ignored" : "R1 ds alone ignored", 32'(seen), 32'd0);
    cs_n = 1'b1; ds_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #150us;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!req_o && !data_oe_o && !ack_oe_o, "R7 reset state",
        {29'd0, req_o, data_oe_o, ack_oe_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 latency: request rises on third edge after strobes low
    rw = 1'b1; addr = 15'h0011; cs_n = 1'b0; ds_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!req_o, "R1 no request before sync", 32'(req_o), 32'd0);
    @(negedge clk);
    chk(req_o, "R1 request after sync", 32'(req_o), 32'd1);
    // R7 async reset mid-access
    rst_n = 1'b0;
    #1;
    chk(!req_o && !ack_oe_o && !data_oe_o, "R7 async reset",
        {29'd0, req_o, data_oe_o, ack_oe_o}, 32'd0);
    cs_n = 1'b1; ds_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    single_strobe(1'b1);
    single_strobe(1'b0);

    // boundary addresses and data
    do_access(1'b1, 15'h7FFF, 16'h0);
    do_access(1'b0, 15'h7FFF, 16'h8001);
    do_access(1'b0, 15'h0000, 16'hFFFE);
    do_access(1'b1, 15'h7FFF, 16'h0);
    do_access(1'b1, 15'h0000, 16'h0);
    do_access(1'b1, 15'h0001, 16'h0);

    for (int i = 0; i < 60; i++) begin
      logic [31:0] rnd;
      logic [AW-1:0] a;
      rnd = $urandom;
      a = rnd[0] ? AW'(rnd[4:1]) : rnd[AW+4:5];
      do_access(rnd[31], a, 16'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule